// File: doc/BRIEF.md
# Palette Lookup Table with Indexed Register Window

The block holds a 256-entry palette of 24-bit colours. A display pipeline looks colours up by presenting an 8-bit pixel index. The matching colour appears on a registered output one cycle later.

A processor reaches the same table through two 32-bit registers on a simple single-cycle bus:

- A pointer register selects the entry. It can be written but not read back.
- A data window reads or writes the selected entry.

Every access to the data window advances the pointer by one, whether it is a read or a write. Software can therefore load or dump the whole palette by setting the pointer once and then streaming accesses to a single address.

The two sides work independently and in the same cycle. The display lookup never stalls the processor, and the processor never stalls the display.

Top module: `pal_lut_top`

## Requirements
- R1: A bus write to byte offset 0x0 (pointer register) loads bits 7:0 of the write data into the pointer. Bits 31:8 are ignored.
- R2: A bus write to byte offset 0x4 (data window) stores write-data bits 23:0 into the entry named by the pointer. Red is in bits 7:0, green in bits 15:8 and blue in bits 23:16. Bits 31:24 are discarded.
- R3: A bus read of offset 0x4 returns the selected entry on bus_rdata in the same cycle, with bits 31:24 zero.
- R4: Every data-window access, read or write, advances the pointer by one at the end of that cycle. Back-to-back reads therefore return consecutive entries.
- R5: The pointer wraps from 255 to 0.
- R6: Reading the pointer register returns zero and leaves the pointer unchanged. Accesses to any other offset also leave the pointer and the table unchanged.
- R7: The display colour pix_color is the table entry at pix_idx, registered, one cycle after pix_idx is presented.
- R8: Display lookups run in the same cycle as processor writes. A display lookup of an entry in the same cycle it is written returns the old colour. A lookup presented in the next cycle returns the new colour.
- R9: While rst_n is low, the pointer is forced to 0 and pix_color to 0. The table contents are not reset.
- R10: bus_rdata is zero in every cycle that is not a data-window read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pix_idx | input | 8 | Display-side palette index |
| pix_color | output | 24 | Colour for pix_idx, one cycle later |

## Verification
The two functions that collide are a processor write through the data window and a display lookup of the very same entry. The bench provokes this by pointing the window at an entry holding a known colour. In one cycle it then issues a data write and presents that entry on pix_idx. It expects the old colour after the first edge and the new colour after the second. A second collision is a data-window read whose pointer increment wraps at 255. Consecutive reads across the wrap must return entry 255 and then entry 0.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Kind of bus access decoded in one cycle
    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_PTR_WR  = 3'd1,
        ACC_PTR_RD  = 3'd2,
        ACC_DATA_WR = 3'd3,
        ACC_DATA_RD = 3'd4
    } pal_acc_e;

endpackage

// File: rtl/pal_regif.sv
module pal_regif
    import pal_pkg::*;
#(
    parameter int                IDX_W    = 8,
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] PTR_OFF  = 'h0,
    parameter logic [ADDR_W-1:0] DATA_OFF = 'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [IDX_W-1:0]  bus_wdata_lo,
    output logic [IDX_W-1:0]  idx_q,
    output logic              mem_we,
    output logic              data_rd
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } regif_st_t;

    regif_st_t st_d, st_q;
    pal_acc_e  acc;

    // Access decode
    always_comb begin
        acc = ACC_NONE;
        if (bus_sel) begin
            if (bus_addr == PTR_OFF)
                acc = bus_wr ? ACC_PTR_WR : ACC_PTR_RD;
            else if (bus_addr == DATA_OFF)
                acc = bus_wr ? ACC_DATA_WR : ACC_DATA_RD;
        end
    end

    // Next state: pointer load or post-access step
    always_comb begin
        st_d = st_q;
        unique case (acc)
            ACC_PTR_WR:               st_d.idx = bus_wdata_lo;
            ACC_DATA_WR, ACC_DATA_RD: st_d.idx = st_q.idx + IDX_W'(1);
            default:                  st_d.idx = st_q.idx;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_q   = st_q.idx;
    assign mem_we  = (acc == ACC_DATA_WR);
    assign data_rd = (acc == ACC_DATA_RD);

endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_we,
    input  logic [IDX_W-1:0]   cpu_idx,
    input  logic [COLOR_W-1:0] cpu_wdata,
    output logic [COLOR_W-1:0] cpu_rdata,
    input  logic [IDX_W-1:0]   pix_idx,
    output logic [COLOR_W-1:0] pix_color
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [COLOR_W-1:0] color;
    } disp_st_t;

    logic [COLOR_W-1:0] mem [DEPTH];
    disp_st_t           disp_d, disp_q;

    // Processor write port
    always_ff @(posedge clk) begin
        if (cpu_we) mem[cpu_idx] <= cpu_wdata;
    end

    // Processor read port: same-cycle
    assign cpu_rdata = mem[cpu_idx];

    // Display read port: registered, sees pre-edge contents
    always_comb begin
        disp_d       = disp_q;
        disp_d.color = mem[pix_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) disp_q <= '0;
        else        disp_q <= disp_d;
    end

    assign pix_color = disp_q.color;

endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top #(
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 24,
    parameter int BUS_W   = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [IDX_W-1:0]   pix_idx,
    output logic [COLOR_W-1:0] pix_color
);

    localparam int PAD_W = BUS_W - COLOR_W;

    logic [IDX_W-1:0]   idx_q;
    logic               mem_we;
    logic               data_rd;
    logic [COLOR_W-1:0] cpu_rdata;
    logic               unused_hi;

    assign unused_hi = ^bus_wdata[BUS_W-1:COLOR_W];

    pal_regif #(
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W),
        .PTR_OFF  (ADDR_W'('h0)),
        .DATA_OFF (ADDR_W'('h4))
    ) regif_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata_lo (bus_wdata[IDX_W-1:0]),
        .idx_q        (idx_q),
        .mem_we       (mem_we),
        .data_rd      (data_rd)
    );

    pal_store #(
        .IDX_W   (IDX_W),
        .COLOR_W (COLOR_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (mem_we),
        .cpu_idx   (idx_q),
        .cpu_wdata (bus_wdata[COLOR_W-1:0]),
        .cpu_rdata (cpu_rdata),
        .pix_idx   (pix_idx),
        .pix_color (pix_color)
    );

    assign bus_rdata = data_rd ? {{PAD_W{1'b0}}, cpu_rdata} : '0;

endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
    parameter int IDX_W  = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [IDX_W-1:0]  cur_idx
);

    logic data_acc, ptr_acc;
    assign data_acc = bus_sel && (bus_addr == ADDR_W'('h4));
    assign ptr_acc  = bus_sel && (bus_addr == ADDR_W'('h0));

    // R1
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_acc && bus_wr) |=> (cur_idx == $past(bus_wdata[IDX_W-1:0])));

    // R4 R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> (cur_idx == IDX_W'($past(cur_idx) + IDX_W'(1))));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_acc && !(ptr_acc && bus_wr)) |=> $stable(cur_idx));

    // R3
    rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !bus_wr) |-> (bus_rdata[BUS_W-1:24] == '0));

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_acc && !bus_wr) |-> (bus_rdata == '0));

endmodule

bind pal_lut_top pal_lut_chk #(
    .IDX_W  (IDX_W),
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cur_idx   (idx_q)
);

// File: tb/pal_lut_top_tb_top.sv
module pal_lut_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] PTR  = 4'h0;
    localparam logic [3:0] DATA = 4'h4;
    localparam logic [3:0] OTHR = 4'h8;

    // {wr, addr[3:0], wdata[31:0], expected rdata[31:0]}
    localparam int NVEC = 13;
    localparam logic [68:0] VEC [NVEC] = '{
        {1'b1, PTR,  32'h0000_0010, 32'h0},          // R1
        {1'b1, DATA, 32'h0011_2233, 32'h0},          // R2
        {1'b1, DATA, 32'hFF44_5566, 32'h0},          // R2 top byte dropped
        {1'b1, DATA, 32'h0077_8899, 32'h0},
        {1'b1, PTR,  32'hABCD_0010, 32'h0},          // R1 upper bits ignored
        {1'b0, DATA, 32'h0,         32'h0011_2233},  // R3
        {1'b0, DATA, 32'h0,         32'h0044_5566},  // R4
        {1'b0, DATA, 32'h0,         32'h0077_8899},  // R4
        {1'b1, PTR,  32'h0000_0011, 32'h0},
        {1'b0, PTR,  32'h0,         32'h0},          // R6
        {1'b0, DATA, 32'h0,         32'h0044_5566},  // R6 pointer held
        {1'b0, OTHR, 32'h0,         32'h0},          // R6 / R10
        {1'b0, DATA, 32'h0,         32'h0077_8899}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_color;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_lut_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pix_idx   (pix_idx),
        .pix_color (pix_color)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [3:0] a, input logic [31:0] wd,
                          output logic [31:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #2;
        // R9 reset values
        chk("R9 pix_color in reset", {8'h0, pix_color}, 32'h0);
        chk("R10 idle rdata", bus_rdata, 32'h0);
        @(negedge clk) rst_n = 1'b1;

        // R9 pointer starts at 0: first data write lands in entry 0
        bus_op(1'b1, DATA, 32'h00AB_CDEF, rd);
        bus_op(1'b1, PTR, 32'h0, rd);
        bus_op(1'b0, DATA, 32'h0, rd);
        chk("R9 pointer reset to 0", rd, 32'h00AB_CDEF);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            bus_op(VEC[i][68], VEC[i][67:64], VEC[i][63:32], rd);
            chk($sformatf("R3/R10 vector %0d", i), rd, VEC[i][31:0]);
        end

        // R5 wrap
        bus_op(1'b1, PTR,  32'h0000_00FF, rd);
        bus_op(1'b1, DATA, 32'h00A1_A2A3, rd);
        bus_op(1'b1, DATA, 32'h00B1_B2B3, rd);
        bus_op(1'b1, PTR,  32'h0000_00FF, rd);
        bus_op(1'b0, DATA, 32'h0, rd);
        chk("R5 entry 255", rd, 32'h00A1_A2A3);
        bus_op(1'b0, DATA, 32'h0, rd);
        chk("R5 wrap to entry 0", rd, 32'h00B1_B2B3);

        // R6 write to an unmapped offset changes nothing
        bus_op(1'b1, PTR,  32'h0000_0020, rd);
        bus_op(1'b1, OTHR, 32'h0000_0021, rd);
        bus_op(1'b1, DATA, 32'h0033_3333, rd);
        bus_op(1'b1, PTR,  32'h0000_0020, rd);
        bus_op(1'b0, DATA, 32'h0, rd);
        chk("R6 unmapped write ignored", rd, 32'h0033_3333);

        // R7 display latency
        @(negedge clk) pix_idx = 8'h00;
        @(negedge clk);
        chk("R7 display entry 0", {8'h0, pix_color}, 32'h00B1_B2B3);
        pix_idx = 8'h10;
        @(negedge clk);
        chk("R7 display entry 0x10", {8'h0, pix_color}, 32'h0011_2233);

        // R8 same-entry collision
        bus_op(1'b1, PTR,  32'h0000_0040, rd);
        bus_op(1'b1, DATA, 32'h000A_0B0C, rd);
        bus_op(1'b1, PTR,  32'h0000_0040, rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = DATA; bus_wdata = 32'h00DD_EEFF;
        pix_idx = 8'h40;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk("R8 old colour in write cycle", {8'h0, pix_color}, 32'h000A_0B0C);
        @(negedge clk);
        chk("R8 new colour next cycle", {8'h0, pix_color}, 32'h00DD_EEFF);

        // R4 write stepped the pointer past 0x40
        bus_op(1'b1, DATA, 32'h0012_1212, rd);
        bus_op(1'b1, PTR,  32'h0000_0041, rd);
        bus_op(1'b0, DATA, 32'h0, rd);
        chk("R4 write advanced pointer", rd, 32'h0012_1212);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule